// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Ports

This block drives and samples a small group of general-purpose port bits. The lowest bits can also act as external interrupt inputs. Each bit is an input or an output, chosen bit by bit in a direction register. An output bit drives the value held in an output data register. A second register holds a per-pin interrupt enable and a per-pin edge polarity. Turning on a pin's interrupt enable makes that pin an input and turns its driver off, whatever its direction bit says. It also arms edge detection on that pin.

A pad level passes through a synchronizer before it is used. A qualifying edge on an armed pin sets a sticky pending flag, which stays set until a clear pulse removes it. The interrupt request is raised when any pending flag is set and the global enable is on. A clock-stop input releases every pad driver, forces the sampled levels to read zero and blocks new pending flags. The configuration is written through a simple strobe port. Nothing in the block streams data, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `extint_port`

## Requirements
- R1: After reset, every pad driver is off (pad_oe all 0). int_pend is 0 and int_req is 0. The direction, output data, interrupt enables, edge selects and global enable all read as 0.
- R2: A write with cfg_sel=0 loads the direction register. cfg_sel=1 loads the output data register. A bit with direction 1 drives (pad_oe=1), a bit with direction 0 does not, and pad_out always shows the output data register. A write takes effect on the clock edge that samples cfg_wr.
- R3: A write with cfg_sel=2 sets the interrupt enables from cfg_wdata[1:0] and the edge selects from cfg_wdata[3:2], with bit i belonging to pin i. When a pin's interrupt enable is 1, its pad_oe is 0 whatever its direction bit says. Pins 2 and 3 have no interrupt function.
- R4: An edge select of 0 detects rising edges and 1 detects falling edges. A pad level change set up before clock edge k sets the matching int_pend bit after edge k+2 and not earlier. An edge of the opposite polarity sets nothing.
- R5: A write with cfg_sel=3 loads the global enable from cfg_wdata[0]. int_req equals the global enable ANDed with the OR of the int_pend bits.
- R6: A pending bit stays set until a pend_clr pulse with a 1 in that bit position is sampled. If a new edge and a clear for the same bit fall on the same clock edge, the bit stays set.
- R7: A pending bit is never set while that pin's interrupt enable is 0. Turning an enable on or off while the pad is steady sets nothing.
- R8: While clk_stop is 1, every pad_oe is 0, every pin_level bit reads 0 and no pending bit becomes set.
- R9: pin_level shows each pad's level after edge k+1 when the pad changed before edge k. This holds for all four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_stop | input | 1 | Clock-stop mode: drivers off, inputs disabled |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 direction, 1 output data, 2 interrupt config, 3 global enable |
| cfg_wdata | input | 4 | Configuration write data |
| pend_clr | input | 2 | Write-one-to-clear pulse for the pending flags |
| pad_in | input | 4 | Pad levels seen at the pins |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad driver enables (0 = high impedance) |
| pin_level | output | 4 | Synchronized pad levels, 0 while stopped |
| int_pend | output | 2 | Sticky pending flags of the interrupt pins |
| int_req | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a new edge and a clear pulse for the same pending bit landing on the same clock edge. To reach it, the bench changes the pad at a known falling clock edge. It counts the two synchronizer stages and asserts pend_clr exactly in the cycle where the edge is detected, while a second, already pending bit is cleared in that same cycle. Clock-stop entry and exit are also exercised with pads toggling during the stop, to show that no stray edge appears afterwards.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SEL_DIR    = 2'd0,
    SEL_DOUT   = 2'd1,
    SEL_IRQCFG = 2'd2,
    SEL_GLOBAL = 2'd3
  } cfg_sel_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/extint_cfg_regs.sv
module extint_cfg_regs
  import extint_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned NUM_INT  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          sel,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_INT-1:0]  ien_q,
  output logic [NUM_INT-1:0]  esel_q,
  output logic                glb_q
);
  localparam int unsigned ESEL_LO = NUM_INT;
  localparam int unsigned ESEL_HI = 2 * NUM_INT - 1;

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
      esel_q <= '0;
      glb_q  <= 1'b0;
    end else if (wr) begin
      case (sel_e)
        SEL_DIR:    dir_q  <= wdata;
        SEL_DOUT:   dout_q <= wdata;
        SEL_IRQCFG: begin
          ien_q  <= wdata[NUM_INT-1:0];
          esel_q <= wdata[ESEL_HI:ESEL_LO];
        end
        SEL_GLOBAL: glb_q  <= wdata[0];
        default:    glb_q  <= glb_q;
      endcase
    end
  end
endmodule

// File: rtl/extint_sync_edge.sv
module extint_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else if (!hold) begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/extint_pend.sv
module extint_pend #(
  parameter int unsigned NUM_INT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop,
  input  logic               glb_en,
  input  logic [NUM_INT-1:0] ien,
  input  logic [NUM_INT-1:0] esel,
  input  logic [NUM_INT-1:0] rise,
  input  logic [NUM_INT-1:0] fall,
  input  logic [NUM_INT-1:0] clr,
  output logic [NUM_INT-1:0] pend_q,
  output logic               req
);
  logic [NUM_INT-1:0] hit;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_hit
    assign hit[i] = (esel[i] ? fall[i] : rise[i]) & ien[i] & ~stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= hit | (pend_q & ~clr);
  end

  assign req = glb_en & (|pend_q);
endmodule

// File: rtl/extint_port.sv
module extint_port
  import extint_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned NUM_INT  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_stop,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_sel,
  input  logic [NUM_PINS-1:0] cfg_wdata,
  input  logic [NUM_INT-1:0]  pend_clr,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_INT-1:0]  int_pend,
  output logic                int_req
);
  logic [NUM_PINS-1:0] dir_q, dout_q;
  logic [NUM_INT-1:0]  ien_q, esel_q;
  logic                glb_q;
  logic [NUM_PINS-1:0] lvl, rise, fall;

  extint_cfg_regs #(.NUM_PINS(NUM_PINS), .NUM_INT(NUM_INT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q), .esel_q(esel_q), .glb_q(glb_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    extint_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .hold(clk_stop), .din(pad_in[i]),
      .level(lvl[i]), .rise(rise[i]), .fall(fall[i])
    );
    assign pin_level[i] = lvl[i] & ~clk_stop;
    assign pad_out[i]   = dout_q[i];
    if (i < NUM_INT) begin : g_irq
      assign pad_oe[i] = dir_q[i] & ~ien_q[i] & ~clk_stop;
    end else begin : g_plain
      assign pad_oe[i] = dir_q[i] & ~clk_stop;
    end
  end

  extint_pend #(.NUM_INT(NUM_INT)) u_pend (
    .clk(clk), .rst_n(rst_n), .stop(clk_stop), .glb_en(glb_q),
    .ien(ien_q), .esel(esel_q),
    .rise(rise[NUM_INT-1:0]), .fall(fall[NUM_INT-1:0]),
    .clr(pend_clr), .pend_q(int_pend), .req(int_req)
  );
endmodule

// File: rtl/extint_port_chk.sv
module extint_port_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned NUM_INT  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clk_stop,
  input logic [NUM_INT-1:0]  pend_clr,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_INT-1:0]  int_pend,
  input logic                int_req,
  input logic [NUM_INT-1:0]  ien_q,
  input logic                glb_q
);
  assert_stop_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (pad_oe == '0));

  assert_req_needs_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> glb_q);

  assert_req_follows_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_q && (int_pend != '0)) |-> int_req);

  for (genvar i = 0; i < NUM_INT; i++) begin : g_bit
    assert_enabled_pin_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ien_q[i] |-> !pad_oe[i]);

    assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int_pend[i] && !pend_clr[i]) |=> int_pend[i]);

    assert_set_only_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_pend[i]) |-> ($past(ien_q[i]) && !$past(clk_stop)));
  end
endmodule

bind extint_port extint_port_chk #(.NUM_PINS(NUM_PINS), .NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .pend_clr(pend_clr),
  .pad_oe(pad_oe), .int_pend(int_pend), .int_req(int_req),
  .ien_q(ien_q), .glb_q(glb_q)
);

// File: tb/tb_extint_port.sv
module tb_extint_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_stop = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [3:0] cfg_wdata = 4'd0;
  logic [1:0] pend_clr = 2'd0;
  logic [3:0] pad_in = 4'd0;
  logic [3:0] pad_out, pad_oe, pin_level;
  logic [1:0] int_pend;
  logic       int_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extint_port dut (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pend_clr(pend_clr),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_level(pin_level), .int_pend(int_pend), .int_req(int_req)
  );

  // {dir, dout, irqcfg, expected pad_oe}
  localparam logic [15:0] VEC [8] = '{
    {4'hF, 4'hA, 4'h0, 4'hF},
    {4'hF, 4'h5, 4'h1, 4'hE},
    {4'hF, 4'h3, 4'h2, 4'hD},
    {4'hF, 4'hC, 4'h3, 4'hC},
    {4'h5, 4'hF, 4'h0, 4'h5},
    {4'hA, 4'h0, 4'h3, 4'h8},
    {4'h0, 4'hF, 4'h0, 4'h0},
    {4'hC, 4'h6, 4'hC, 4'hC}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    pend_clr = m;
    step(1);
    pend_clr = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 pad_oe", 8'(pad_oe), 8'h0);
    chk("R1 pad_out", 8'(pad_out), 8'h0);
    chk("R1 int_pend", 8'(int_pend), 8'h0);
    chk("R1 int_req", 8'(int_req), 8'h0);
    chk("R1 pin_level", 8'(pin_level), 8'h0);

    // R2/R3 table walk
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, VEC[v][15:12]);
      wr(2'd1, VEC[v][11:8]);
      wr(2'd2, VEC[v][7:4]);
      chk("R2/R3 pad_oe", 8'(pad_oe), 8'(VEC[v][3:0]));
      chk("R2 pad_out", 8'(pad_out), 8'(VEC[v][11:8]));
    end
    wr(2'd0, 4'h0);
    wr(2'd2, 4'h0);
    chk("R7 no pending from enable toggles", 8'(int_pend), 8'h0);

    // R4 rising on pin0, latency
    wr(2'd2, 4'b0011);
    pad_in = 4'b0001;
    step(2);
    chk("R9 pin_level latency", 8'(pin_level), 8'h1);
    chk("R4 pending not early", 8'(int_pend), 8'h0);
    step(1);
    chk("R4 rising sets pending", 8'(int_pend), 8'h1);
    chk("R5 req gated by global", 8'(int_req), 8'h0);
    wr(2'd3, 4'h1);
    chk("R5 req with global", 8'(int_req), 8'h1);
    step(10);
    chk("R6 pending sticky", 8'(int_pend), 8'h1);
    clr(2'b01);
    chk("R6 clear", 8'(int_pend), 8'h0);
    chk("R5 req drops", 8'(int_req), 8'h0);

    // R4 falling select on pin0, rising on pin1
    wr(2'd2, 4'b0111);
    pad_in = 4'b0000;
    step(3);
    chk("R4 falling sets pin0", 8'(int_pend), 8'h1);
    pad_in = 4'b0010;
    step(3);
    chk("R4 rising sets pin1", 8'(int_pend), 8'h3);
    clr(2'b11);
    chk("R6 clear both", 8'(int_pend), 8'h0);
    pad_in = 4'b0011;
    step(3);
    chk("R4 wrong polarity ignored", 8'(int_pend), 8'h0);

    // R6 set wins over clear in same cycle
    pad_in = 4'b0001;
    step(3);
    pad_in = 4'b0011;
    step(3);
    chk("R4 pin1 pending", 8'(int_pend), 8'h2);
    pad_in = 4'b0010;
    step(2);
    pend_clr = 2'b11;
    step(1);
    pend_clr = 2'b00;
    chk("R6 set beats clear", 8'(int_pend), 8'h1);

    // R7 disabled pins ignore edges
    wr(2'd2, 4'b0000);
    clr(2'b11);
    pad_in = 4'b0011;
    step(4);
    pad_in = 4'b0000;
    step(4);
    chk("R7 disabled edges ignored", 8'(int_pend), 8'h0);
    chk("R7 no request", 8'(int_req), 8'h0);

    // R8 clock stop
    wr(2'd0, 4'hF);
    wr(2'd1, 4'hF);
    chk("R2 all driving", 8'(pad_oe), 8'hF);
    clk_stop = 1'b1;
    pad_in = 4'b1111;
    #0.1;
    chk("R8 drivers off", 8'(pad_oe), 8'h0);
    chk("R8 level reads zero", 8'(pin_level), 8'h0);
    wr(2'd2, 4'b0011);
    step(5);
    chk("R8 no pending in stop", 8'(int_pend), 8'h0);
    pad_in = 4'b0000;
    step(1);
    clk_stop = 1'b0;
    step(4);
    chk("R8 no pending after exit", 8'(int_pend), 8'h0);
    chk("R3 enabled pins undriven", 8'(pad_oe), 8'hC);

    // R9 plain bits
    pad_in = 4'b1100;
    step(2);
    chk("R9 plain bit levels", 8'(pin_level), 8'hC);
    step(2);
    chk("R3 plain bits no pending", 8'(int_pend), 8'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule